// File: doc/BRIEF.md
# Two-Level Interrupt Cause Controller

This block gathers up to 64 level-sensitive interrupt requests into a 64-bit cause vector. A 64-bit enable mask, written by a 32-bit CPU as two independent halves, chooses which causes reach a single CPU interrupt line. Both halves of the cause vector can be read back over the register bus.

A select read gives the interrupt handler the one half of the cause vector that holds enabled pending work. A flag bit says which half it returned, so a 32-bit processor can find its source among 64 with a single load. Some cause positions are reserved: they never latch a request and always read as zero. The two flag positions (bit 30 of the upper word and bit 31 of the lower word) fall on reserved bits, so a flag never hides a real cause.

Top module: `irq_cause_ctrl`

## Requirements
- R1: After reset the cause vector and the mask are all zero, `irq_o` is low, and every register reads zero.
- R2: A source input held high sets its cause bit at the next clock edge. Dropping the input clears the bit at the next clock edge.
- R3: Cause bits 29–31, 51–55 and 61–63 are reserved. They stay zero whatever their source inputs do.
- R4: Reading address 0 returns cause bits 31:0. Reading address 1 returns cause bits 63:32.
- R5: A write to address 2 loads mask bits 31:0 and leaves mask bits 63:32 unchanged. Reading address 2 returns mask bits 31:0.
- R6: A write to address 3 loads mask bits 63:32 and leaves mask bits 31:0 unchanged. Reading address 3 returns mask bits 63:32.
- R7: `irq_o` is the OR of all 64 bits of (cause AND mask). It changes only in a cycle where that masked value has changed.
- R8: When no enabled cause is pending, the select read (address 4) returns cause bits 31:0 unchanged.
- R9: When every enabled pending cause lies in bits 63:32, the select read returns cause bits 63:32 with bit 30 set.
- R10: When enabled causes are pending in both halves, the select read returns cause bits 31:0 with bit 31 set.
- R11: When enabled pending causes lie only in bits 31:0, the select read returns cause bits 31:0 with no flag.
- R12: Writes to addresses 0, 1 and 4 change neither the cause vector nor the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 64 | Level interrupt requests, one per cause bit |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | CPU interrupt request |

## Verification
A source edge and a mask write can land on the same clock edge. In that case the interrupt line must depend on the new values of both, with no cycle of stale output. The bench triggers this by raising an upper-half source and writing the matching upper mask bit in the same cycle. It then expects `irq_o` high right after that edge and the select read to show the upper word flagged. It also lets the cause vector and the select encoding move together: a select read is sampled in the cycle after a source changes, and its flags are judged against the updated halves.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned N_HALF  = 2;
  localparam int unsigned CAUSE_W = WORD_W * N_HALF;
  localparam int unsigned REG_AW  = 3;

  localparam logic [CAUSE_W-1:0] RSVD_MASK = 64'hE0F8_0000_E000_0000;

  typedef enum logic [REG_AW-1:0] {
    A_CAUSE_LO = 3'd0,
    A_CAUSE_HI = 3'd1,
    A_MASK_LO  = 3'd2,
    A_MASK_HI  = 3'd3,
    A_SELECT   = 3'd4
  } reg_addr_e;

  localparam int unsigned FLAG_HI_BIT = 30;
  localparam int unsigned FLAG_LO_BIT = 31;
endpackage

// File: rtl/irq_cause_reg.sv
module irq_cause_reg
  import irq_cause_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CAUSE_W-1:0] src_i,
  output logic [CAUSE_W-1:0] cause_o
);
  logic [CAUSE_W-1:0] cause_q;

  for (genvar b = 0; b < CAUSE_W; b++) begin : g_bit
    if (RSVD_MASK[b]) begin : g_rsvd
      always_comb cause_q[b] = 1'b0;
    end else begin : g_live
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cause_q[b] <= 1'b0;
        else         cause_q[b] <= src_i[b];
      end
    end
  end

  assign cause_o = cause_q;
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import irq_cause_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_HALF-1:0]  half_we_i,
  input  logic [WORD_W-1:0]  wdata_i,
  output logic [CAUSE_W-1:0] mask_o
);
  for (genvar h = 0; h < N_HALF; h++) begin : g_half
    logic [WORD_W-1:0] half_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          half_q <= '0;
      else if (half_we_i[h]) half_q <= wdata_i;
    end
    assign mask_o[h*WORD_W +: WORD_W] = half_q;
  end
endmodule

// File: rtl/irq_select_enc.sv
module irq_select_enc
  import irq_cause_pkg::*;
(
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [CAUSE_W-1:0] mask_i,
  output logic [WORD_W-1:0]  sel_o,
  output logic               any_o
);
  logic [CAUSE_W-1:0] pend;
  logic               lo_pend, hi_pend;

  assign pend    = cause_i & mask_i;
  assign lo_pend = |pend[WORD_W-1:0];
  assign hi_pend = |pend[CAUSE_W-1:WORD_W];
  assign any_o   = lo_pend | hi_pend;

  always_comb begin
    sel_o = cause_i[WORD_W-1:0];
    if (hi_pend && !lo_pend) begin
      sel_o = cause_i[CAUSE_W-1:WORD_W];
      sel_o[FLAG_HI_BIT] = 1'b1;
    end else if (hi_pend && lo_pend) begin
      sel_o[FLAG_LO_BIT] = 1'b1;
    end
  end
endmodule

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl
  import irq_cause_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CAUSE_W-1:0] src_i,
  input  logic               bus_we_i,
  input  logic [REG_AW-1:0]  bus_addr_i,
  input  logic [WORD_W-1:0]  bus_wdata_i,
  output logic [WORD_W-1:0]  bus_rdata_o,
  output logic               irq_o
);
  logic [CAUSE_W-1:0] cause_q;
  logic [CAUSE_W-1:0] mask_q;
  logic [N_HALF-1:0]  mask_we;
  logic [WORD_W-1:0]  sel_word;
  logic               any_pend;

  assign mask_we[0] = bus_we_i && (bus_addr_i == A_MASK_LO);
  assign mask_we[1] = bus_we_i && (bus_addr_i == A_MASK_HI);

  irq_cause_reg u_cause (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (src_i),
    .cause_o(cause_q)
  );

  irq_mask_reg u_mask (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .half_we_i(mask_we),
    .wdata_i  (bus_wdata_i),
    .mask_o   (mask_q)
  );

  irq_select_enc u_sel (
    .cause_i(cause_q),
    .mask_i (mask_q),
    .sel_o  (sel_word),
    .any_o  (any_pend)
  );

  assign irq_o = any_pend;

  always_comb begin
    unique case (bus_addr_i)
      A_CAUSE_LO: bus_rdata_o = cause_q[WORD_W-1:0];
      A_CAUSE_HI: bus_rdata_o = cause_q[CAUSE_W-1:WORD_W];
      A_MASK_LO:  bus_rdata_o = mask_q[WORD_W-1:0];
      A_MASK_HI:  bus_rdata_o = mask_q[CAUSE_W-1:WORD_W];
      A_SELECT:   bus_rdata_o = sel_word;
      default:    bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_cause_ctrl_chk.sv
module irq_cause_ctrl_chk
  import irq_cause_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [CAUSE_W-1:0] src_i,
  input logic               bus_we_i,
  input logic [REG_AW-1:0]  bus_addr_i,
  input logic [WORD_W-1:0]  bus_rdata_o,
  input logic               irq_o,
  input logic [CAUSE_W-1:0] cause_q,
  input logic [CAUSE_W-1:0] mask_q
);
  logic [CAUSE_W-1:0] masked;
  assign masked = cause_q & mask_q;

  a_r2_cause_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> cause_q == ($past(src_i) & ~RSVD_MASK));

  a_r3_rsvd_lo_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_addr_i == A_CAUSE_LO |-> (bus_rdata_o & RSVD_MASK[WORD_W-1:0]) == '0);

  a_r3_rsvd_hi_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_addr_i == A_CAUSE_HI |-> (bus_rdata_o & RSVD_MASK[CAUSE_W-1:WORD_W]) == '0);

  a_r5_lo_keeps_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_i && bus_addr_i == A_MASK_LO |=> $stable(mask_q[CAUSE_W-1:WORD_W]));

  a_r6_hi_keeps_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_i && bus_addr_i == A_MASK_HI |=> $stable(mask_q[WORD_W-1:0]));

  a_r7_irq_on_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o != $past(irq_o) |-> masked != $past(masked));

  a_r9_flag_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_addr_i == A_SELECT && masked[WORD_W-1:0] == '0 && masked[CAUSE_W-1:WORD_W] != '0
    |-> bus_rdata_o[FLAG_HI_BIT]);

  a_r10_flag_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_addr_i == A_SELECT && masked[WORD_W-1:0] != '0 && masked[CAUSE_W-1:WORD_W] != '0
    |-> bus_rdata_o[FLAG_LO_BIT]);

  a_r12_cause_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_i && (bus_addr_i == A_CAUSE_LO || bus_addr_i == A_CAUSE_HI || bus_addr_i == A_SELECT)
    |=> $stable(mask_q));
endmodule

bind irq_cause_ctrl irq_cause_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .src_i      (src_i),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .bus_rdata_o(bus_rdata_o),
  .irq_o      (irq_o),
  .cause_q    (cause_q),
  .mask_q     (mask_q)
);

// File: tb/irq_cause_ctrl_test.sv
module irq_cause_ctrl_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] src_i = '0;
  logic        bus_we_i = 1'b0;
  logic [2:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  irq_cause_ctrl uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i), .bus_we_i(bus_we_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i);
    bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr_i = a;
    #1 d = bus_rdata_o;
  endtask

  task automatic drive_src(input logic [63:0] v);
    @(negedge clk_i);
    src_i = v;
    @(negedge clk_i);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 irq", {31'd0, irq_o}, 32'd0);
    for (int a = 0; a < 5; a++) begin
      rd(a[2:0], d);
      check("R1 reg", d, 32'd0);
    end
  endtask

  task automatic t_cause;
    logic [31:0] d;
    drive_src(64'h0000_0400_0000_0081);
    rd(3'd0, d); check("R2 R4 cause lo", d, 32'h0000_0081);
    rd(3'd1, d); check("R2 R4 cause hi", d, 32'h0000_0400);
    drive_src(64'h0000_0400_0000_0001);
    rd(3'd0, d); check("R2 release", d, 32'h0000_0001);
    drive_src('0);
    rd(3'd1, d); check("R2 release hi", d, 32'h0);
  endtask

  task automatic t_reserved;
    logic [31:0] d;
    drive_src({64{1'b1}});
    rd(3'd0, d); check("R3 lo", d, 32'h1FFF_FFFF);
    rd(3'd1, d); check("R3 hi", d, 32'h1F07_FFFF);
    drive_src('0);
  endtask

  task automatic t_mask_halves;
    logic [31:0] d;
    wr(3'd2, 32'hA5A5_0F0F);
    wr(3'd3, 32'h1234_5678);
    rd(3'd2, d); check("R5 lo", d, 32'hA5A5_0F0F);
    rd(3'd3, d); check("R6 hi", d, 32'h1234_5678);
    wr(3'd2, 32'h0000_0001);
    rd(3'd3, d); check("R5 hi kept", d, 32'h1234_5678);
    wr(3'd3, 32'h0);
    rd(3'd2, d); check("R6 lo kept", d, 32'h0000_0001);
    wr(3'd2, 32'h0);
  endtask

  task automatic t_irq;
    drive_src(64'h0000_0000_0000_0020);
    check("R7 unmasked", {31'd0, irq_o}, 32'd0);
    wr(3'd2, 32'h0000_0020);
    check("R7 masked on", {31'd0, irq_o}, 32'd1);
    drive_src('0);
    check("R7 src off", {31'd0, irq_o}, 32'd0);
    wr(3'd2, 32'h0);
  endtask

  task automatic t_select;
    logic [31:0] d;
    drive_src({32'h0000_0100, 32'h0000_0004});
    rd(3'd4, d); check("R8 none", d, 32'h0000_0004);
    wr(3'd3, 32'h0000_0100);
    rd(3'd4, d); check("R9 upper", d, 32'h4000_0100);
    wr(3'd2, 32'h0000_0004);
    rd(3'd4, d); check("R10 both", d, 32'h8000_0004);
    wr(3'd3, 32'h0);
    rd(3'd4, d); check("R11 lower", d, 32'h0000_0004);
    wr(3'd2, 32'h0);
    drive_src('0);
  endtask

  task automatic t_ignored;
    logic [31:0] d;
    wr(3'd2, 32'h0000_00F0);
    wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd0, d); check("R12 cause lo", d, 32'h0);
    rd(3'd1, d); check("R12 cause hi", d, 32'h0);
    rd(3'd2, d); check("R12 mask lo", d, 32'h0000_00F0);
    rd(3'd3, d); check("R12 mask hi", d, 32'h0);
    check("R12 irq", {31'd0, irq_o}, 32'd0);
    wr(3'd2, 32'h0);
  endtask

  task automatic t_same_cycle;
    logic [31:0] d;
    @(negedge clk_i);
    src_i = 64'h0000_0100_0000_0000;
    bus_we_i = 1'b1; bus_addr_i = 3'd3; bus_wdata_i = 32'h0000_0100;
    @(negedge clk_i);
    bus_we_i = 1'b0;
    check("R7 same edge irq", {31'd0, irq_o}, 32'd1);
    rd(3'd4, d); check("R9 same edge sel", d, 32'h4000_0100);
    drive_src(64'h0000_0100_0000_0002);
    rd(3'd4, d); check("R11 R8 lo unmasked", d, 32'h4000_0100);
    drive_src('0);
    check("R7 drop", {31'd0, irq_o}, 32'd0);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_cause();
    t_reserved();
    t_mask_halves();
    t_irq();
    t_select();
    t_ignored();
    t_same_cycle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule